// File: doc/BRIEF.md
# Dual-Pixel to Single-Pixel Video Formatter

This block sits behind a two-link video receiver. On every edge of the slow pixel clock (`clk_px`), it takes two recovered 30-bit RGB pixels, one from link A and one from link B. Each pixel comes with its own horizontal sync, vertical sync and data-enable bits. The block re-emits the pixels as a single parallel stream on a clock of twice the rate (`clk_dbl`), one pixel per fast edge. The two clocks are phase aligned: every rising edge of `clk_px` coincides with a rising edge of `clk_dbl`.

Ahead of the output register, two static strap inputs reshape each pixel. A three-bit code chooses which colour component drives each of the three output channels. A single bit chooses whether each 10-bit channel keeps its natural bit order or is mirrored. An output-enable input freezes every output at its last value.

The stream is rate locked, so it has no valid/ready handshake and no back-pressure. The producer must present a new pair on every `clk_px` edge, and the consumer must accept one pixel on every `clk_dbl` edge. De-asserting `oe` does not stall the stream. Pixels that arrive while the outputs are frozen are dropped, and the stream resumes on schedule.

Top module: `dpx_formatter`

## Requirements
- R1: While `rst_n` is low at a `clk_dbl` edge, every output is cleared to zero on that edge. Reset is synchronous in both clock domains.
- R2: A pair captured on a `clk_px` edge is emitted as follows. The link A pixel reaches the outputs on the first `clk_dbl` edge after the capture edge. The link B pixel follows on the second `clk_dbl` edge.
- R3: `out_hs`, `out_vs` and `out_de` carry the sync and enable bits of the link whose pixel is on the data outputs in the same cycle.
- R4: `cmap_sel` chooses the source (red, green, blue) for each output channel (out_red, out_grn, out_blu). `cmap_sel` is read as a binary number, written here as bits 2, 1, 0:
  - 111 gives (R,G,B)
  - 110 gives (R,B,G)
  - 101 gives (B,R,G)
  - 100 gives (B,G,R)
  - 011 gives (G,R,B)
  - 010 gives (G,B,R)
- R5: `cmap_sel` codes 001 and 000 both give the identity mapping (R,G,B).
- R6: With `msb_hi`=1, each output channel's bit i equals bit i of its source. With `msb_hi`=0, bit i equals bit 9-i of its source. The bit order applies to all three channels at once.
- R7: On a `clk_dbl` edge where `oe` is 0, every data, sync and enable output keeps its value. When `oe` returns to 1, the output carries the pixel scheduled for that edge by R2.
- R8: The strap inputs are applied combinationally ahead of the output register. A change made before a `clk_dbl` edge applies to the pixel loaded on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_px | input | 1 | Input pair clock (1x) |
| clk_dbl | input | 1 | Output pixel clock (2x), phase aligned to clk_px |
| rst_n | input | 1 | Synchronous active-low reset |
| a_red | input | 10 | Link A red |
| a_grn | input | 10 | Link A green |
| a_blu | input | 10 | Link A blue |
| a_hs | input | 1 | Link A horizontal sync |
| a_vs | input | 1 | Link A vertical sync |
| a_de | input | 1 | Link A data enable |
| b_red | input | 10 | Link B red |
| b_grn | input | 10 | Link B green |
| b_blu | input | 10 | Link B blue |
| b_hs | input | 1 | Link B horizontal sync |
| b_vs | input | 1 | Link B vertical sync |
| b_de | input | 1 | Link B data enable |
| oe | input | 1 | Output enable; 0 freezes all outputs |
| cmap_sel | input | 3 | Colour routing code |
| msb_hi | input | 1 | 1: natural bit order, 0: mirrored |
| out_red | output | 10 | Output red channel |
| out_grn | output | 10 | Output green channel |
| out_blu | output | 10 | Output blue channel |
| out_hs | output | 1 | Output horizontal sync |
| out_vs | output | 1 | Output vertical sync |
| out_de | output | 1 | Output data enable |

## Verification
If the phase tracker falls out of step, the link B pixel shows up in the slot meant for link A, or one pixel repeats. The sync bits then move to the wrong slot too, so the error appears on the first fast edge after a capture. A wrong route or mirror entry corrupts every pixel loaded under that code in the very next cycle. For that reason every code and both bit orders are held long enough to be compared. A freeze that leaks shows as an output change on an edge with `oe` low, and a freeze that sticks shows as a stale pixel once `oe` returns.

// File: rtl/dpx_pkg.sv
package dpx_pkg;
  localparam int unsigned DPX_CW = 10;

  typedef enum logic [1:0] {
    SRC_RED = 2'd0,
    SRC_GRN = 2'd1,
    SRC_BLU = 2'd2
  } src_e;

  // Source channel for output channel ch (0 red, 1 green, 2 blue).
  function automatic src_e route_src(input logic [2:0] code, input int ch);
    src_e t [3];
    case (code)
      3'b110:  t = '{SRC_RED, SRC_BLU, SRC_GRN};
      3'b101:  t = '{SRC_BLU, SRC_RED, SRC_GRN};
      3'b100:  t = '{SRC_BLU, SRC_GRN, SRC_RED};
      3'b011:  t = '{SRC_GRN, SRC_RED, SRC_BLU};
      3'b010:  t = '{SRC_GRN, SRC_BLU, SRC_RED};
      default: t = '{SRC_RED, SRC_GRN, SRC_BLU};
    endcase
    return t[ch];
  endfunction
endpackage

// File: rtl/dpx_capture.sv
module dpx_capture #(
  parameter int unsigned PW = 33
) (
  input  logic          clk_px,
  input  logic          rst_n,
  input  logic [PW-1:0] in_a,
  input  logic [PW-1:0] in_b,
  output logic [PW-1:0] stg_a,
  output logic [PW-1:0] stg_b,
  output logic          cap_tog
);
  // Pair staging; cap_tog flips once per captured pair.
  always_ff @(posedge clk_px) begin
    if (!rst_n) begin
      stg_a   <= '0;
      stg_b   <= '0;
      cap_tog <= 1'b0;
    end else begin
      stg_a   <= in_a;
      stg_b   <= in_b;
      cap_tog <= ~cap_tog;
    end
  end
endmodule

// File: rtl/dpx_phase.sv
module dpx_phase #(
  parameter int unsigned PW = 33
) (
  input  logic          clk_dbl,
  input  logic          rst_n,
  input  logic          cap_tog,
  input  logic [PW-1:0] stg_a,
  input  logic [PW-1:0] stg_b,
  output logic [PW-1:0] sel_px,
  output logic          pick_a
);
  logic seen_tog;

  // A pair not yet seen in the fast domain means link A goes out now.
  assign pick_a = cap_tog ^ seen_tog;
  assign sel_px = pick_a ? stg_a : stg_b;

  always_ff @(posedge clk_dbl) begin
    if (!rst_n) seen_tog <= 1'b0;
    else        seen_tog <= cap_tog;
  end

  AST_B_FOLLOWS_A: assert property (@(posedge clk_dbl) disable iff (!rst_n)
    pick_a |=> !pick_a); // R2
endmodule

// File: rtl/dpx_route.sv
module dpx_route #(
  parameter int unsigned CW = dpx_pkg::DPX_CW,
  localparam int unsigned PW = 3*CW + 3
) (
  input  logic [2:0]    cmap_sel,
  input  logic          msb_hi,
  input  logic [PW-1:0] pix_in,
  output logic [PW-1:0] pix_out
);
  import dpx_pkg::*;

  src_e src [3];

  for (genvar ch = 0; ch < 3; ch++) begin : g_chan
    logic [CW-1:0] chosen;
    logic [CW-1:0] mirror;
    assign src[ch] = route_src(cmap_sel, ch);
    assign chosen  = pix_in[int'(src[ch])*CW +: CW];
    for (genvar b = 0; b < CW; b++) begin : g_bit
      assign mirror[b] = chosen[CW-1-b];
    end
    assign pix_out[ch*CW +: CW] = msb_hi ? chosen : mirror;
  end

  assign pix_out[PW-1:3*CW] = pix_in[PW-1:3*CW];

  always_comb begin
    if (!$isunknown(cmap_sel)) begin
      AST_ROUTE_IS_PERMUTATION: assert (src[0] != src[1] && src[1] != src[2] && src[0] != src[2]); // R4
    end
    if (!$isunknown({pix_in, msb_hi, cmap_sel})) begin
      AST_BITS_CONSERVED: assert ($countones(pix_out) == $countones(pix_in)); // R6
    end
  end
endmodule

// File: rtl/dpx_outreg.sv
module dpx_outreg #(
  parameter int unsigned PW = 33
) (
  input  logic          clk_dbl,
  input  logic          rst_n,
  input  logic          oe,
  input  logic [PW-1:0] d,
  output logic [PW-1:0] q
);
  always_ff @(posedge clk_dbl) begin
    if (!rst_n)  q <= '0;
    else if (oe) q <= d;
  end

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk_dbl) disable iff (!rst_n)
    ($past(rst_n) && !$past(oe)) |-> $stable(q)); // R7
endmodule

// File: rtl/dpx_formatter.sv
module dpx_formatter #(
  parameter int unsigned CW = dpx_pkg::DPX_CW,
  localparam int unsigned PW = 3*CW + 3
) (
  input  logic          clk_px,
  input  logic          clk_dbl,
  input  logic          rst_n,
  input  logic [CW-1:0] a_red,
  input  logic [CW-1:0] a_grn,
  input  logic [CW-1:0] a_blu,
  input  logic          a_hs,
  input  logic          a_vs,
  input  logic          a_de,
  input  logic [CW-1:0] b_red,
  input  logic [CW-1:0] b_grn,
  input  logic [CW-1:0] b_blu,
  input  logic          b_hs,
  input  logic          b_vs,
  input  logic          b_de,
  input  logic          oe,
  input  logic [2:0]    cmap_sel,
  input  logic          msb_hi,
  output logic [CW-1:0] out_red,
  output logic [CW-1:0] out_grn,
  output logic [CW-1:0] out_blu,
  output logic          out_hs,
  output logic          out_vs,
  output logic          out_de
);
  // Pixel word: {hs, vs, de, blue, green, red}.
  logic [PW-1:0] in_a, in_b, stg_a, stg_b, sel_px, fmt_px, q;
  logic          cap_tog, pick_a;

  assign in_a = {a_hs, a_vs, a_de, a_blu, a_grn, a_red};
  assign in_b = {b_hs, b_vs, b_de, b_blu, b_grn, b_red};

  dpx_capture #(.PW(PW)) u_capture (
    .clk_px(clk_px), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
    .stg_a(stg_a), .stg_b(stg_b), .cap_tog(cap_tog)
  );

  dpx_phase #(.PW(PW)) u_phase (
    .clk_dbl(clk_dbl), .rst_n(rst_n), .cap_tog(cap_tog),
    .stg_a(stg_a), .stg_b(stg_b), .sel_px(sel_px), .pick_a(pick_a)
  );

  dpx_route #(.CW(CW)) u_route (
    .cmap_sel(cmap_sel), .msb_hi(msb_hi), .pix_in(sel_px), .pix_out(fmt_px)
  );

  dpx_outreg #(.PW(PW)) u_outreg (
    .clk_dbl(clk_dbl), .rst_n(rst_n), .oe(oe), .d(fmt_px), .q(q)
  );

  assign out_red = q[0*CW +: CW];
  assign out_grn = q[1*CW +: CW];
  assign out_blu = q[2*CW +: CW];
  assign out_de  = q[3*CW];
  assign out_vs  = q[3*CW+1];
  assign out_hs  = q[3*CW+2];
endmodule

// File: tb/dpx_formatter_test.sv
module dpx_formatter_test;
  localparam int CW = 10;
  localparam int PW = 3*CW + 3;

  logic clk_px = 1'b0, clk_dbl = 1'b0, rst_n = 1'b0;
  logic [PW-1:0] in_a = '0, in_b = '0;
  logic oe = 1'b1, msb_hi = 1'b1;
  logic [2:0] cmap_sel = 3'b111;
  logic [CW-1:0] out_red, out_grn, out_blu;
  logic out_hs, out_vs, out_de;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  // Reference state (built from the requirements).
  logic [PW-1:0] m_a = '0, m_b = '0, m_q = '0;
  bit m_fresh = 0;
  logic [2:0] last_code = 3'b111;
  logic last_msb = 1'b1;
  string tag_dat = "R1", tag_syn = "R1";

  dpx_formatter uut (
    .clk_px(clk_px), .clk_dbl(clk_dbl), .rst_n(rst_n),
    .a_red(in_a[CW-1:0]), .a_grn(in_a[2*CW-1:CW]), .a_blu(in_a[3*CW-1:2*CW]),
    .a_hs(in_a[3*CW+2]), .a_vs(in_a[3*CW+1]), .a_de(in_a[3*CW]),
    .b_red(in_b[CW-1:0]), .b_grn(in_b[2*CW-1:CW]), .b_blu(in_b[3*CW-1:2*CW]),
    .b_hs(in_b[3*CW+2]), .b_vs(in_b[3*CW+1]), .b_de(in_b[3*CW]),
    .oe(oe), .cmap_sel(cmap_sel), .msb_hi(msb_hi),
    .out_red(out_red), .out_grn(out_grn), .out_blu(out_blu),
    .out_hs(out_hs), .out_vs(out_vs), .out_de(out_de)
  );

  always #10 clk_dbl = ~clk_dbl;            // 50 MHz output clock
  initial begin
    #10;
    forever begin clk_px = 1'b1; #20; clk_px = 1'b0; #20; end
  end

  function automatic logic [CW-1:0] pick_ch(input logic [3*CW-1:0] d, input int s);
    return d[s*CW +: CW];
  endfunction

  function automatic logic [CW-1:0] mirror(input logic [CW-1:0] v);
    logic [CW-1:0] r;
    for (int i = 0; i < CW; i++) r[i] = v[CW-1-i];
    return r;
  endfunction

  // R4 / R5 table: sources for (red, green, blue) outputs; 0=R 1=G 2=B.
  function automatic logic [3*CW-1:0] expect_fmt(input logic [3*CW-1:0] d,
                                                 input logic [2:0] code, input logic msb);
    int s0, s1, s2;
    logic [CW-1:0] c0, c1, c2;
    case (code)
      3'b110: begin s0 = 0; s1 = 2; s2 = 1; end
      3'b101: begin s0 = 2; s1 = 0; s2 = 1; end
      3'b100: begin s0 = 2; s1 = 1; s2 = 0; end
      3'b011: begin s0 = 1; s1 = 0; s2 = 2; end
      3'b010: begin s0 = 1; s1 = 2; s2 = 0; end
      default: begin s0 = 0; s1 = 1; s2 = 2; end
    endcase
    c0 = pick_ch(d, s0); c1 = pick_ch(d, s1); c2 = pick_ch(d, s2);
    if (!msb) begin c0 = mirror(c0); c1 = mirror(c1); c2 = mirror(c2); end
    return {c2, c1, c0};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Called at a clk_dbl negedge after inputs are driven: predicts the next rising edge.
  task automatic model_edge();
    logic [PW-1:0] src;
    bit at_px = (clk_px == 1'b0);
    bit strap_chg = (cmap_sel != last_code) || (msb_hi != last_msb);
    if (!rst_n) begin
      m_q = '0; m_fresh = 0;
      if (at_px) begin m_a = '0; m_b = '0; end
      tag_dat = "R1"; tag_syn = "R1";
    end else begin
      if (oe) begin
        src = m_fresh ? m_a : m_b;
        m_q = {src[PW-1:3*CW], expect_fmt(src[3*CW-1:0], cmap_sel, msb_hi)};
        tag_syn = "R3";
        if (strap_chg) tag_dat = "R8";
        else if (cmap_sel <= 3'b001) tag_dat = "R5";
        else if (!msb_hi) tag_dat = "R6";
        else if (cmap_sel == 3'b111) tag_dat = "R2";
        else tag_dat = "R4";
      end else begin
        tag_dat = "R7"; tag_syn = "R7";
      end
      m_fresh = 0;
      if (at_px) begin m_a = in_a; m_b = in_b; m_fresh = 1; end
    end
    last_code = cmap_sel; last_msb = msb_hi;
  endtask

  task automatic compare_all();
    check(tag_dat, "red", 32'(out_red), 32'(m_q[CW-1:0]));
    check(tag_dat, "grn", 32'(out_grn), 32'(m_q[2*CW-1:CW]));
    check(tag_dat, "blu", 32'(out_blu), 32'(m_q[3*CW-1:2*CW]));
    check(tag_syn, "sync", 32'({out_hs, out_vs, out_de}), 32'(m_q[PW-1:3*CW]));
  endtask

  // mode bit0: random straps each cycle; bit1: random oe.
  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_dbl);
      compare_all();
      in_a = {$urandom, $urandom};
      in_b = {$urandom, $urandom};
      if (mode[0]) begin cmap_sel = 3'($urandom); msb_hi = 1'($urandom); end
      if (mode[1]) oe = ($urandom % 4) != 0;
      model_edge();
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    // R1: reset with live inputs.
    run(8, 0);
    @(negedge clk_dbl);
    compare_all();
    check("R1", "reset zero", 32'({out_red, out_hs}), 32'd0);
    rst_n = 1'b1;
    model_edge();
    // R2 / R3: identity straps, steady stream.
    run(200, 0);
    // R4 / R5 / R6: every code under both bit orders.
    for (int c = 0; c < 8; c++) begin
      for (int m = 0; m < 2; m++) begin
        @(negedge clk_dbl);
        compare_all();
        cmap_sel = 3'(c); msb_hi = 1'(m);
        model_edge();
        run(24, 0);
      end
    end
    // R7: directed freeze across several edges, then random enable.
    @(negedge clk_dbl);
    compare_all();
    oe = 1'b0;
    model_edge();
    run(9, 0);
    @(negedge clk_dbl);
    compare_all();
    oe = 1'b1;
    model_edge();
    run(300, 2);
    // R8: straps changing every edge, with and without freeze.
    run(300, 1);
    run(200, 3);
    // Reset again mid-stream (R1).
    @(negedge clk_dbl);
    compare_all();
    rst_n = 1'b0;
    model_edge();
    run(6, 1);
    @(negedge clk_dbl);
    compare_all();
    rst_n = 1'b1;
    model_edge();
    run(40, 0);
    @(negedge clk_dbl);
    compare_all();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog expired: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule